// File: doc/BRIEF.md
# Transmit Endpoint Status Register

This block holds the status word that a local processor reads for one transmit endpoint. The low field shows how many bytes of the endpoint's FIFO are still empty, clipped to the largest value the field can hold. The three upper bits are flags that the endpoint protocol engine updates through one-cycle event strobes: a done flag, an acknowledge bit and an underrun flag.

The done flag rises when the endpoint has answered the host. Three things can cause this: an ordinary data packet finishing in non-isochronous mode, a STALL answer, or a scheduled isochronous frame being sent or dropped. The acknowledge bit is loaded each time the done flag is set, so it describes the handshake that belongs to that done event. The done flag and the underrun flag clear after the processor reads the word. If a new event arrives in the same cycle as the read, the event wins and is not lost.

The free-space field is combinational from the FIFO count. The flags are registered and change on the clock edge that follows their strobe. The FIFO and the protocol engine sit outside this block.

Top module: `tx_ep_status`

## Requirements
- R1: The read word places the underrun flag at bit 7, the acknowledge bit at bit 6, the done flag at bit 5 and the free-space field at bits 4..0.
- R2: The free-space field equals the FIFO free count in the same cycle when that count is at most 31, and it reads 31 whenever the count is larger.
- R3: A packet-sent strobe with the isochronous mode input at 0 sets the done flag on the next edge. With the mode input at 1 that strobe has no effect on the done flag.
- R4: A STALL-sent strobe sets the done flag on the next edge, in either mode.
- R5: An isochronous-frame strobe with the mode input at 1 sets the done flag on the next edge. With the mode input at 0 that strobe has no effect on the done flag.
- R6: A read strobe clears the done flag on the next edge. The word seen during the read cycle still shows the value held before the clear.
- R7: An underrun strobe sets the underrun flag on the next edge. A read strobe clears it on the next edge.
- R8: When a set event and a read strobe fall in the same cycle, the affected flag is 1 after the edge.
- R9: In every cycle in which the done flag is being set, the acknowledge bit is loaded. It takes 1 only when the mode input is 0, a packet-sent strobe and an ACK-received strobe are both present, and no STALL-sent strobe is present. Otherwise it takes 0. In all other cycles, reads included, the acknowledge bit keeps its value.
- R10: After reset all three flags are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| free_cnt | input | CNT_W | Number of empty bytes in the transmit FIFO |
| iso_mode | input | 1 | Endpoint is isochronous when 1 |
| ev_pkt_sent | input | 1 | Data packet finished in answer to an IN token |
| ev_stall_sent | input | 1 | STALL handshake sent in answer to an IN token |
| ev_iso_frame | input | 1 | Scheduled isochronous frame sent or discarded |
| ev_ack_rcvd | input | 1 | Host ACK received for the packet being completed |
| ev_underrun | input | 1 | Transmit FIFO underrun |
| rd_stb | input | 1 | Processor read of the status word |
| rd_data | output | FIELD_W+3 | Status word |

## Verification
The bench builds the block twice. The main instance uses a 7-bit count and a 5-bit field, so a sweep over all 128 count values crosses the clipping point at 31 and reaches the widest overflow. A second instance uses a 4-bit count, which selects the pass-through variant of the field logic. For the flags, the bench drives every one of the 8 reachable starting states of the flags and, from each of them, all 128 combinations of the five strobes, the mode input and the read strobe. This reaches every collision between a set event and a read, and every mix of done sources, against a model of the flags computed inside the bench.

// File: rtl/tx_stat_pkg.sv
package tx_stat_pkg;
   // Number of flag bits above the free-space field.
   localparam int unsigned FLAG_BITS = 3;

   // Flag layout in the upper bits of the status word, MSB first.
   typedef struct packed {
      logic urun;
      logic ack;
      logic done;
   } tx_flags_t;
endpackage

// File: rtl/tx_space_sat.sv
module tx_space_sat #(
   parameter int unsigned CNT_W   = 7,
   parameter int unsigned FIELD_W = 5
) (
   input  logic [CNT_W-1:0]   cnt,
   output logic [FIELD_W-1:0] field
);
   localparam logic [FIELD_W-1:0] FMAX = {FIELD_W{1'b1}};

   generate
      if (CNT_W > FIELD_W) begin : g_clip
         logic over;
         assign over  = |cnt[CNT_W-1:FIELD_W];
         assign field = over ? FMAX : cnt[FIELD_W-1:0];
      end else begin : g_pass
         assign field = FIELD_W'(cnt);
      end
   endgenerate
endmodule

// File: rtl/tx_sticky_flag.sv
module tx_sticky_flag (
   input  logic clk,
   input  logic rst_n,
   input  logic set,
   input  logic clr,
   output logic q
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   q <= 1'b0;
      else if (set) q <= 1'b1;
      else if (clr) q <= 1'b0;
   end

   // R8: a set in the same cycle as a clear leaves the flag at 1
   p_set_wins_r8: assert property (@(posedge clk) disable iff (!rst_n)
      set |=> q);
   // R6 / R7: a clear with no set empties the flag
   p_flag_clr_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (clr && !set) |=> !q);
   p_flag_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (!clr && !set) |=> $stable(q));
endmodule

// File: rtl/tx_ack_track.sv
module tx_ack_track (
   input  logic clk,
   input  logic rst_n,
   input  logic load,
   input  logic val,
   output logic q
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    q <= 1'b0;
      else if (load) q <= val;
   end

   // R9: outside a done event the acknowledge bit is held
   p_ack_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
      !load |=> $stable(q));
endmodule

// File: rtl/tx_done_src.sv
module tx_done_src (
   input  logic iso_mode,
   input  logic pkt_sent,
   input  logic stall_sent,
   input  logic iso_frame,
   input  logic ack_rcvd,
   output logic done_set,
   output logic ack_val
);
   logic pkt_ok;
   logic frame_ok;

   always_comb begin
      pkt_ok   = pkt_sent  & ~iso_mode;
      frame_ok = iso_frame &  iso_mode;
      done_set = pkt_ok | frame_ok | stall_sent;
      ack_val  = pkt_ok & ack_rcvd & ~stall_sent;
   end
endmodule

// File: rtl/tx_ep_status.sv
module tx_ep_status #(
   parameter int unsigned CNT_W   = 7,
   parameter int unsigned FIELD_W = 5,
   localparam int unsigned REG_W  = FIELD_W + tx_stat_pkg::FLAG_BITS
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [CNT_W-1:0] free_cnt,
   input  logic             iso_mode,
   input  logic             ev_pkt_sent,
   input  logic             ev_stall_sent,
   input  logic             ev_iso_frame,
   input  logic             ev_ack_rcvd,
   input  logic             ev_underrun,
   input  logic             rd_stb,
   output logic [REG_W-1:0] rd_data
);
   import tx_stat_pkg::*;

   localparam logic [FIELD_W-1:0] FMAX = {FIELD_W{1'b1}};

   generate
      if (CNT_W < 1 || FIELD_W < 1) begin : g_bad_width
         $error("tx_ep_status: widths must be at least 1");
      end
   endgenerate

   logic [FIELD_W-1:0] space_field;
   logic               done_set;
   logic               ack_val;
   tx_flags_t          flags;

   tx_space_sat #(.CNT_W(CNT_W), .FIELD_W(FIELD_W)) u_sat (
      .cnt   (free_cnt),
      .field (space_field)
   );

   tx_done_src u_src (
      .iso_mode   (iso_mode),
      .pkt_sent   (ev_pkt_sent),
      .stall_sent (ev_stall_sent),
      .iso_frame  (ev_iso_frame),
      .ack_rcvd   (ev_ack_rcvd),
      .done_set   (done_set),
      .ack_val    (ack_val)
   );

   tx_sticky_flag u_done (
      .clk (clk), .rst_n (rst_n), .set (done_set), .clr (rd_stb), .q (flags.done)
   );

   tx_sticky_flag u_urun (
      .clk (clk), .rst_n (rst_n), .set (ev_underrun), .clr (rd_stb), .q (flags.urun)
   );

   tx_ack_track u_ack (
      .clk (clk), .rst_n (rst_n), .load (done_set), .val (ack_val), .q (flags.ack)
   );

   assign rd_data = {flags, space_field};

   // R2: the field never exceeds its ceiling and clips large counts
   p_clip_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (free_cnt > CNT_W'(FMAX)) |-> (rd_data[FIELD_W-1:0] == FMAX));
   // R3: a packet strobe in isochronous mode does not set done
   p_iso_pkt_ignored_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_stb && iso_mode && !ev_stall_sent && !ev_iso_frame) |=> !rd_data[FIELD_W]);
   // R4: a STALL always sets done
   p_stall_done_r4: assert property (@(posedge clk) disable iff (!rst_n)
      ev_stall_sent |=> rd_data[FIELD_W]);
   // R5: a frame strobe outside isochronous mode does not set done
   p_frame_ignored_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_stb && !iso_mode && !ev_stall_sent && !ev_pkt_sent) |=> !rd_data[FIELD_W]);
   // R7: an underrun strobe raises bit 7
   p_urun_set_r7: assert property (@(posedge clk) disable iff (!rst_n)
      ev_underrun |=> rd_data[REG_W-1]);
endmodule

// File: tb/tx_ep_status_bench.sv
`timescale 1ns/1ps
module tx_ep_status_bench;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [6:0] free_cnt = '0;
   logic [3:0] free_n = '0;
   logic       iso_mode = 1'b0;
   logic       ev_pkt_sent = 1'b0;
   logic       ev_stall_sent = 1'b0;
   logic       ev_iso_frame = 1'b0;
   logic       ev_ack_rcvd = 1'b0;
   logic       ev_underrun = 1'b0;
   logic       rd_stb = 1'b0;
   logic [7:0] rd_data;
   logic [6:0] rd_data_n;

   int total = 0;
   int bad = 0;
   bit finished = 1'b0;

   // Bench model of the flags
   logic m_done, m_ack, m_urun;

   always #2.5 clk = ~clk;

   tx_ep_status #(.CNT_W(7), .FIELD_W(5)) u_tx_ep_status (
      .clk, .rst_n, .free_cnt, .iso_mode, .ev_pkt_sent, .ev_stall_sent,
      .ev_iso_frame, .ev_ack_rcvd, .ev_underrun, .rd_stb, .rd_data
   );

   tx_ep_status #(.CNT_W(4), .FIELD_W(4)) u_tx_ep_status_narrow (
      .clk, .rst_n, .free_cnt (free_n), .iso_mode, .ev_pkt_sent, .ev_stall_sent,
      .ev_iso_frame, .ev_ack_rcvd, .ev_underrun, .rd_stb, .rd_data (rd_data_n)
   );

   task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   function automatic logic [7:0] expect_word(input logic [6:0] cnt);
      logic [4:0] f;
      f = (cnt > 7'd31) ? 5'd31 : cnt[4:0];
      return {m_urun, m_ack, m_done, f};
   endfunction

   // b: [0] pkt [1] stall [2] frame [3] ack [4] underrun [5] iso [6] read
   task automatic cyc(input logic [6:0] b);
      logic dset;
      ev_pkt_sent   = b[0];
      ev_stall_sent = b[1];
      ev_iso_frame  = b[2];
      ev_ack_rcvd   = b[3];
      ev_underrun   = b[4];
      iso_mode      = b[5];
      rd_stb        = b[6];
      dset = (b[0] & ~b[5]) | b[1] | (b[2] & b[5]);
      @(posedge clk);
      if (dset) m_ack = ~b[5] & b[0] & b[3] & ~b[1];
      m_done = dset | (m_done & ~b[6]);
      m_urun = b[4] | (m_urun & ~b[6]);
      @(negedge clk);
      {ev_pkt_sent, ev_stall_sent, ev_iso_frame, ev_ack_rcvd, ev_underrun, iso_mode, rd_stb} = '0;
   endtask

   initial begin
      #(200000 * 5);
      if (!finished) begin
         total++;
         bad++;
         $display("FAIL watchdog actual=hung expected=done");
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      m_done = 1'b0; m_ack = 1'b0; m_urun = 1'b0;
      free_cnt = 7'd40;
      #1;
      chk("R10 in reset", rd_data, 8'h1F);
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R10 after reset", rd_data, 8'h1F);

      // R1 / R2: count sweep, flags all zero
      for (int v = 0; v < 128; v++) begin
         free_cnt = 7'(v);
         free_n   = 4'(v);
         #1;
         chk("R2 clip sweep", rd_data, expect_word(7'(v)));
         chk("R2 narrow pass", {1'b0, rd_data_n}, {4'b0, 4'(v)});
      end
      free_cnt = 7'd45;
      @(negedge clk);

      // R3 R4 R5 R6 R7 R8 R9: every start state against every input mix
      for (int pre = 0; pre < 8; pre++) begin
         for (int c = 0; c < 128; c++) begin
            cyc(7'b1000000);
            if (pre[1]) cyc(7'b0001001);
            else        cyc(7'b0000010);
            cyc(7'b1000000);
            cyc({2'b00, pre[2], pre[1], 1'b0, pre[0] & ~pre[1], pre[0] & pre[1]});
            chk("R1 start state", rd_data, expect_word(free_cnt));
            ev_pkt_sent   = c[0];
            ev_stall_sent = c[1];
            ev_iso_frame  = c[2];
            ev_ack_rcvd   = c[3];
            ev_underrun   = c[4];
            iso_mode      = c[5];
            rd_stb        = c[6];
            #1;
            chk("R6 value during read", rd_data, expect_word(free_cnt));
            @(negedge clk);
            cyc(7'(c));
            chk("R3/R4/R5/R7/R8/R9 after event mix", rd_data, expect_word(free_cnt));
         end
      end

      finished = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule